// File: doc/BRIEF.md
# Completion buffer space limiter

This block sits on the read-request path of a bus endpoint whose link partner is told that completion space is unlimited. The partner therefore never holds back returning read data, yet the local receive buffer for that data has a fixed size. The limiter keeps a running count of the buffer space claimed by memory reads that have been sent but not yet answered. It lets a new read pass only when the buffer is sure to hold its data.

Space is counted in 16-byte units, which are four dwords. The buffer size is a static input in those units. Each request claims its dword length rounded up to whole units. Each returning completion frees its own dword count, rounded the same way. The downstream ready is passed through to the requester only while the next request still fits strictly below capacity. A grant and a release in the same cycle are merged into one update of the count.

Top module: `cpl_space_limiter`

## Requirements
- R1: After reset the outstanding count is zero, so any request whose units are below the capacity is offered ready.
- R2: A request of L dwords claims ceil(L/4) units, and a length field of 0 means 1024 dwords, which is 256 units.
- R3: `req_ready` is high exactly when `dn_ready` is high and the outstanding count plus the units of `req_len` is strictly less than `cap_units`. A request is granted when `req_valid` and `req_ready` are both high.
- R4: While `cap_units` is nonzero the outstanding count always stays strictly below `cap_units`.
- R5: A cycle with `cpl_valid` high frees ceil(`cpl_len`/4) units, and a `cpl_len` of 0 means 1024 dwords.
- R6: The outstanding count saturates at zero and never wraps below it when the freed units exceed the count.
- R7: A grant and a release in one cycle are applied as a single net update. Admission in that cycle uses the count from before the release.
- R8: When `dn_ready` is low, `req_ready` is low and a valid request claims no space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_units | input | CAP_W | Static buffer size in 16-byte units |
| req_valid | input | 1 | Read request offered |
| req_len | input | LEN_W | Request length in dwords (0 = 1024) |
| dn_ready | input | 1 | Downstream can accept a request |
| req_ready | output | 1 | Gated ready back to the requester |
| cpl_valid | input | 1 | Completion data received this cycle |
| cpl_len | input | LEN_W | Completion dword count (0 = 1024) |

## Verification
Directed runs drive the count to one unit below capacity and then offer a one-unit request. This separates a strict bound from a less-or-equal bound. A 1024-dword request against a capacity of 300 units separates the zero-length encoding from a request of zero length. Lengths of 172 and 173 dwords probe the rounding to whole units. A same-cycle grant and release that is refused at capacity shows that admission uses the count from before the release. An oversized release followed by a request that fits only from zero exposes any wraparound below zero. Long constrained-random runs at tiny and large capacities mix downstream stalls, requests and completions, so the running count is checked across many interleavings.

// File: rtl/cpl_space_limiter.sv
module cpl_space_limiter #(
  parameter int CAP_W = 12,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap_units,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             dn_ready,
  output logic             req_ready,
  input  logic             cpl_valid,
  input  logic [LEN_W-1:0] cpl_len
);
  localparam int UNIT_W = LEN_W - 1;
  localparam int CNT_W  = CAP_W + 1;

  function automatic logic [UNIT_W-1:0] to_units(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] full;
    logic [LEN_W:0] up;
    full = (len == '0) ? (LEN_W+1)'(1) << LEN_W : {1'b0, len};
    up   = (full + (LEN_W+1)'(3)) >> 2;
    return up[UNIT_W-1:0];
  endfunction

  logic [CAP_W-1:0]  used_q;
  logic [UNIT_W-1:0] req_u, cpl_u;
  logic [CNT_W-1:0]  need, grow, drop, nxt;
  logic              fits, grant;

  assign req_u = to_units(req_len);
  assign cpl_u = to_units(cpl_len);
  assign need  = CNT_W'(used_q) + CNT_W'(req_u);
  assign fits  = need < CNT_W'(cap_units);
  assign req_ready = dn_ready & fits;
  assign grant = req_valid & req_ready;
  assign grow  = grant ? need : CNT_W'(used_q);
  assign drop  = cpl_valid ? CNT_W'(cpl_u) : '0;
  assign nxt   = (grow > drop) ? grow - drop : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= nxt[CAP_W-1:0];
  end

  // R4: the claimed space never reaches capacity
  a_r4_below_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_units != '0) |-> (used_q < cap_units));

  // R8: no ready towards the requester without downstream ready
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready |-> !req_ready);

  // R7: with neither grant nor release the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant && !cpl_valid) |=> $stable(used_q));

  // R6: a release from an empty count leaves it empty
  a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q == '0 && !grant && cpl_valid) |=> (used_q == '0));

  // R3: a grant never shrinks the count when nothing is released
  a_r3_grant_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !cpl_valid) |=> (used_q > $past(used_q)));
endmodule

// File: tb/test_cpl_space_limiter.sv
`timescale 1ns/1ps
module test_cpl_space_limiter;
  logic clk = 0, rst_n = 0;
  logic [11:0] cap_units = 12'd16;
  logic req_valid = 0, dn_ready = 0, cpl_valid = 0;
  logic [9:0] req_len = 0, cpl_len = 0;
  logic req_ready;
  int total = 0, bad = 0, m_cnt = 0, m_cap = 16;
  bit done = 0;

  always #4 clk = ~clk;

  cpl_space_limiter i_cpl_space_limiter (
    .clk(clk), .rst_n(rst_n), .cap_units(cap_units), .req_valid(req_valid),
    .req_len(req_len), .dn_ready(dn_ready), .req_ready(req_ready),
    .cpl_valid(cpl_valid), .cpl_len(cpl_len));

  function automatic int units(input int l);
    return (l == 0) ? 256 : (l + 3) / 4;
  endfunction

  task automatic do_reset(input int cap);
    rst_n = 0; req_valid = 0; cpl_valid = 0; dn_ready = 0;
    cap_units = 12'(cap); m_cap = cap; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input bit v, input bit dn, input int len,
                      input bit cv, input int clen, input string tag);
    bit exp, g;
    int tmp, c;
    req_valid = v; dn_ready = dn; req_len = 10'(len);
    cpl_valid = cv; cpl_len = 10'(clen);
    #1;
    exp = dn && (m_cnt + units(len % 1024) < m_cap);
    total++;
    if (req_ready !== exp) begin
      bad++;
      $display("FAIL %s: req_ready=%0b expected %0b (count %0d cap %0d len %0d)",
               tag, req_ready, exp, m_cnt, m_cap, len);
    end
    @(posedge clk);
    g = v && exp;
    tmp = m_cnt + (g ? units(len % 1024) : 0);
    c = cv ? units(clen % 1024) : 0;
    m_cnt = (tmp > c) ? tmp - c : 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(16);
    step(0, 1, 4, 0, 0, "R1");       // empty after reset
    step(1, 1, 60, 0, 0, "R3");      // 15 units granted
    step(1, 1, 1, 0, 0, "R3");       // 15+1 == 16 refused
    step(1, 0, 1, 0, 0, "R8");       // downstream stall
    step(0, 1, 1, 1, 5, "R5");       // frees 2 units -> 13
    step(1, 1, 8, 0, 0, "R3");       // 13+2 < 16 granted -> 15
    step(1, 1, 4, 1, 4, "R7");       // refused on pre-release count, -> 14
    step(1, 1, 4, 1, 4, "R7");       // grant and release net zero -> 14
    step(0, 1, 4, 1, 0, "R6");       // free 256, floor at 0
    step(0, 1, 60, 0, 0, "R6");      // fits only from zero
    do_reset(300);
    step(1, 1, 0, 0, 0, "R2");       // 1024 dwords = 256 units
    step(0, 1, 172, 0, 0, "R2");     // 43 units -> 299 fits
    step(0, 1, 173, 0, 0, "R2");     // 44 units -> 300 refused
    do_reset(0);
    step(1, 1, 1, 0, 0, "R3");       // zero capacity admits nothing
    for (int p = 0; p < 8; p++) begin
      int cap;
      cap = (p % 2 == 0) ? int'($urandom % 40) : int'($urandom % 4096);
      do_reset(cap);
      for (int i = 0; i < 2000; i++) begin
        step($urandom % 3 != 0, $urandom % 4 != 0, int'($urandom % 1024),
             $urandom % 3 == 0, int'($urandom % 64), "R4");
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule